// File: doc/BRIEF.md
# Dual-Bank Flash Operation Tracker

This block models the control side of a two-bank flash array. A host issues word-wide reads and command writes; at most one embedded program or erase runs at a time, and the bank that holds it is the busy bank. Reads aimed at the other bank keep returning array contents on the same one-cycle schedule as an idle array. Reads aimed at the busy bank return a status word, with a completion-poll bit and two toggle bits, which software uses to track progress. A ready output stays low while an operation runs.

Program and erase lengths come from cycle counters, and the array is a small bank of registers. Programming can only clear bits, and erase fills a whole sector with ones. An erase can be suspended so that a program can run elsewhere in the same bank, and it continues from where it stopped once resumed. Each sector has a protect line. A boot-lock input also guards the two outermost sectors, whatever their protect lines say. An asynchronous reset aborts any operation.

Top module: `dual_bank_flash_ctl`

## Requirements
- R1: Bank 0 holds the lowest `(NUM_SECTORS/8) << SPLIT_SEL` sectors and bank 1 holds the rest. SPLIT_SEL 0, 1 and 2 give the 1/8, 1/4 and 1/2 splits. The sector number is the upper address field above the word-in-sector bits.
- R2: `rdValid` rises exactly one cycle after `rdEn`. Then `rdData` carries the array word at `rdAddr` whenever the address is outside the busy bank, with no extra wait while the other bank is busy.
- R3: A read of the busy bank returns a status word in which every bit other than 7, 6 and 2 is 0. Bit 7 is the complement of bit 7 of the word being programmed during a program, 0 during a running erase, and 1 while an erase is only suspended.
- R4: `ready` is low for exactly PROG_CYCLES cycles after an accepted program and for exactly ERASE_CYCLES cycles of erase time, summed across suspensions. No single busy stretch exceeds ERASE_CYCLES.
- R5: When an operation completes, `ready` returns high and reads of that bank return array data with no further command.
- R6: `rstN` low aborts any operation, forces `ready` high and returns the model's array to all ones.
- R7: Command code 2 (suspend) during an erase makes `ready` high. A program to a different sector in the same bank is then accepted. A program to the suspended sector is rejected. Code 3 (resume) continues the erase with its remaining time.
- R8: While `wpEn` is high, program and erase commands to the two outermost sectors are rejected. These are sectors 0 and 1 when TOP_BOOT is 0, and the top two sectors otherwise.
- R9: A program or erase to a sector whose `secProtect` bit is 1 is rejected and leaves `ready` high.
- R10: A completed program stores the old word AND the written data. A completed erase sets every word of its sector to all ones.
- R11: Bit 6 of the status word inverts on every busy-bank read while a program or erase runs. Bit 2 inverts only on reads whose sector is the one being erased or the suspended one.
- R12: Command code 0 is program and code 1 is erase. Either one issued while a program or erase is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset and operation abort |
| wrEn | input | 1 | Command write strobe |
| wrCmd | input | 2 | Command code: 0 program, 1 erase, 2 suspend, 3 resume |
| wrAddr | input | ADDR_W | Word address of the command |
| wrData | input | DATA_W | Program data |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | ADDR_W | Word address of the read |
| rdData | output | DATA_W | Array word or status word, one cycle after rdEn |
| rdValid | output | 1 | Marks rdData as the answer to the previous cycle's read |
| wpEn | input | 1 | Boot-sector lock |
| secProtect | input | NUM_SECTORS | Per-sector protect lines |
| ready | output | 1 | High when no program or erase is running |

## Verification
The bound checker checks the following on every cycle:
- `ready` under reset.
- The one-cycle read handshake.
- Rejection of commands to locked or protected sectors, seen as `ready` staying high.
- `ready` returning after every completion strobe.
- The upper bound on any busy stretch.

Only the bench's scenarios can show the data-dependent behaviour:
- Stored values after AND-programming and erase.
- Array reads served from the idle bank during an operation.
- The status-word bits and their toggling pattern.
- The summed erase time across a suspend with a program inside it.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  typedef enum logic [1:0] {
    CMD_PROG    = 2'd0,
    CMD_ERASE   = 2'd1,
    CMD_SUSPEND = 2'd2,
    CMD_RESUME  = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_ERASE, ST_SUSP, ST_SUSP_PROG
  } opState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic progActive;
    logic eraseActive;
    logic suspended;
    logic doProg;
    logic doErase;
  } ctlStrobe_t;
endpackage

// File: rtl/dbf_ctrl.sv
module dbf_ctrl
  import dbf_pkg::*;
#(
  parameter int NUM_SECTORS      = 8,
  parameter int WORDS_PER_SECTOR = 4,
  parameter int DATA_W           = 16,
  parameter int PROG_CYCLES      = 6,
  parameter int ERASE_CYCLES     = 16,
  parameter int SPLIT_SEL        = 1,
  parameter bit TOP_BOOT         = 1'b0,
  localparam int WORD_W = $clog2(WORDS_PER_SECTOR),
  localparam int SEC_W  = $clog2(NUM_SECTORS),
  localparam int ADDR_W = SEC_W + WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrCmd,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wpEn,
  input  logic [NUM_SECTORS-1:0] secProtect,
  output ctlStrobe_t        ctl,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic [SEC_W-1:0]  eraseSec,
  output logic              ready
);
  localparam int BANK0_SECS = (NUM_SECTORS / 8) << SPLIT_SEL;
  localparam int PW = $clog2(PROG_CYCLES + 1);
  localparam int EW = $clog2(ERASE_CYCLES + 1);

  function automatic logic bankOf(input logic [SEC_W-1:0] s);
    return int'(s) >= BANK0_SECS;
  endfunction

  opState_e state;
  logic [PW-1:0] progTmr;
  logic [EW-1:0] eraseTmr;
  logic [SEC_W-1:0] wrSec;
  logic isBoot, locked, sameBank;
  cmd_e cmd;

  assign cmd   = cmd_e'(wrCmd);
  assign wrSec = wrAddr[ADDR_W-1:WORD_W];

  generate
    if (TOP_BOOT) begin : g_topBoot
      assign isBoot = int'(wrSec) >= NUM_SECTORS - 2;
    end else begin : g_botBoot
      assign isBoot = int'(wrSec) < 2;
    end
  endgenerate

  assign locked   = secProtect[wrSec] || (wpEn && isBoot);
  assign sameBank = bankOf(wrSec) == bankOf(eraseSec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      progTmr  <= '0;
      eraseTmr <= '0;
      opAddr   <= '0;
      opData   <= '0;
      eraseSec <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (wrEn && !locked) begin
          if (cmd == CMD_PROG) begin
            state   <= ST_PROG;
            opAddr  <= wrAddr;
            opData  <= wrData;
            progTmr <= PW'(PROG_CYCLES);
          end else if (cmd == CMD_ERASE) begin
            state    <= ST_ERASE;
            eraseSec <= wrSec;
            eraseTmr <= EW'(ERASE_CYCLES);
          end
        end
        ST_PROG: begin
          if (progTmr == PW'(1)) state <= ST_IDLE;
          else progTmr <= progTmr - PW'(1);
        end
        ST_ERASE: begin
          if (eraseTmr == EW'(1)) state <= ST_IDLE;
          else begin
            eraseTmr <= eraseTmr - EW'(1);
            if (wrEn && cmd == CMD_SUSPEND) state <= ST_SUSP;
          end
        end
        ST_SUSP: if (wrEn) begin
          if (cmd == CMD_RESUME) state <= ST_ERASE;
          else if (cmd == CMD_PROG && !locked && sameBank && wrSec != eraseSec) begin
            state   <= ST_SUSP_PROG;
            opAddr  <= wrAddr;
            opData  <= wrData;
            progTmr <= PW'(PROG_CYCLES);
          end
        end
        ST_SUSP_PROG: begin
          if (progTmr == PW'(1)) state <= ST_SUSP;
          else progTmr <= progTmr - PW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.progActive  = (state == ST_PROG) || (state == ST_SUSP_PROG);
    ctl.eraseActive = (state == ST_ERASE);
    ctl.suspended   = (state == ST_SUSP) || (state == ST_SUSP_PROG);
    ctl.doProg      = ctl.progActive && progTmr == PW'(1);
    ctl.doErase     = ctl.eraseActive && eraseTmr == EW'(1);
  end

  assign ready = (state == ST_IDLE) || (state == ST_SUSP);
endmodule

// File: rtl/dbf_datapath.sv
module dbf_datapath
  import dbf_pkg::*;
#(
  parameter int NUM_SECTORS      = 8,
  parameter int WORDS_PER_SECTOR = 4,
  parameter int DATA_W           = 16,
  parameter int SPLIT_SEL        = 1,
  localparam int WORD_W = $clog2(WORDS_PER_SECTOR),
  localparam int SEC_W  = $clog2(NUM_SECTORS),
  localparam int ADDR_W = SEC_W + WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  input  logic [SEC_W-1:0]  eraseSec,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int WORDS      = NUM_SECTORS * WORDS_PER_SECTOR;
  localparam int BANK0_SECS = (NUM_SECTORS / 8) << SPLIT_SEL;

  function automatic logic bankOf(input logic [SEC_W-1:0] s);
    return int'(s) >= BANK0_SECS;
  endfunction

  logic [DATA_W-1:0] mem [WORDS];
  logic [SEC_W-1:0]  rdSec;
  logic busyBank, opRunning, inErase, statHit, tog6, tog2;
  logic [DATA_W-1:0] statWord;

  assign rdSec     = rdAddr[ADDR_W-1:WORD_W];
  assign opRunning = ctl.progActive || ctl.eraseActive;
  assign busyBank  = ctl.progActive ? bankOf(opAddr[ADDR_W-1:WORD_W]) : bankOf(eraseSec);
  assign inErase   = (ctl.eraseActive || ctl.suspended) && rdSec == eraseSec;
  assign statHit   = (opRunning && bankOf(rdSec) == busyBank)
                   || (ctl.suspended && rdSec == eraseSec);

  always_comb begin
    statWord    = '0;
    statWord[7] = ctl.progActive ? ~opData[7] : !ctl.eraseActive;
    statWord[6] = tog6;
    statWord[2] = tog2;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (ctl.doProg) begin
      mem[opAddr] <= mem[opAddr] & opData;
    end else if (ctl.doErase) begin
      for (int w = 0; w < WORDS_PER_SECTOR; w++) mem[{eraseSec, WORD_W'(w)}] <= '1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
      tog6    <= 1'b0;
      tog2    <= 1'b0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) begin
        rdData <= statHit ? statWord : mem[rdAddr];
        if (statHit && opRunning) tog6 <= ~tog6;
        if (statHit && inErase) tog2 <= ~tog2;
      end
    end
  end
endmodule

// File: rtl/dual_bank_flash_ctl.sv
module dual_bank_flash_ctl
  import dbf_pkg::*;
#(
  parameter int NUM_SECTORS      = 8,
  parameter int WORDS_PER_SECTOR = 4,
  parameter int DATA_W           = 16,
  parameter int PROG_CYCLES      = 6,
  parameter int ERASE_CYCLES     = 16,
  parameter int SPLIT_SEL        = 1,
  parameter bit TOP_BOOT         = 1'b0,
  localparam int WORD_W = $clog2(WORDS_PER_SECTOR),
  localparam int SEC_W  = $clog2(NUM_SECTORS),
  localparam int ADDR_W = SEC_W + WORD_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [1:0]             wrCmd,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic                   rdEn,
  input  logic [ADDR_W-1:0]      rdAddr,
  output logic [DATA_W-1:0]      rdData,
  output logic                   rdValid,
  input  logic                   wpEn,
  input  logic [NUM_SECTORS-1:0] secProtect,
  output logic                   ready
);
  ctlStrobe_t        ctl;
  logic [ADDR_W-1:0] opAddr;
  logic [DATA_W-1:0] opData;
  logic [SEC_W-1:0]  eraseSec;

  dbf_ctrl #(
    .NUM_SECTORS(NUM_SECTORS), .WORDS_PER_SECTOR(WORDS_PER_SECTOR), .DATA_W(DATA_W),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES), .SPLIT_SEL(SPLIT_SEL),
    .TOP_BOOT(TOP_BOOT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCmd(wrCmd), .wrAddr(wrAddr),
    .wrData(wrData), .wpEn(wpEn), .secProtect(secProtect), .ctl(ctl),
    .opAddr(opAddr), .opData(opData), .eraseSec(eraseSec), .ready(ready)
  );

  dbf_datapath #(
    .NUM_SECTORS(NUM_SECTORS), .WORDS_PER_SECTOR(WORDS_PER_SECTOR), .DATA_W(DATA_W),
    .SPLIT_SEL(SPLIT_SEL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opAddr(opAddr), .opData(opData),
    .eraseSec(eraseSec), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .rdValid(rdValid)
  );
endmodule

// File: rtl/dbf_chk.sv
module dbf_chk
  import dbf_pkg::*;
#(
  parameter int NUM_SECTORS  = 8,
  parameter int ERASE_CYCLES = 16,
  parameter bit TOP_BOOT     = 1'b0,
  localparam int SEC_W = $clog2(NUM_SECTORS)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrEn,
  input logic [1:0]             wrCmd,
  input logic [SEC_W-1:0]       wrSec,
  input logic                   rdEn,
  input logic                   rdValid,
  input logic                   wpEn,
  input logic [NUM_SECTORS-1:0] secProtect,
  input logic                   ready,
  input logic                   opDone
);
  localparam int RW = $clog2(ERASE_CYCLES + 2);

  logic progOrErase, bootHit;
  logic [RW-1:0] busyRun;

  assign progOrErase = wrCmd == CMD_PROG || wrCmd == CMD_ERASE;
  assign bootHit = TOP_BOOT ? (int'(wrSec) >= NUM_SECTORS - 2) : (int'(wrSec) < 2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else if (ready) busyRun <= '0;
    else if (busyRun < RW'(ERASE_CYCLES + 1)) busyRun <= busyRun + RW'(1);
  end

  // R6: reset leaves the block ready
  p_reset_ready_r6: assert property (@(posedge clk) !rstN |=> ready);

  // R2: read answered exactly one cycle later
  p_rd_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);
  p_rd_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

  // R8: boot lock rejects program/erase
  p_wp_block_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ready && wpEn && bootHit && progOrErase) |=> ready);

  // R9: sector protect rejects program/erase
  p_protect_block_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ready && secProtect[wrSec] && progOrErase) |=> ready);

  // R5: completion returns to ready
  p_done_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> ready);

  // R4: no busy stretch longer than the erase time
  p_busy_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> busyRun < RW'(ERASE_CYCLES));
endmodule

bind dual_bank_flash_ctl dbf_chk #(
  .NUM_SECTORS(NUM_SECTORS), .ERASE_CYCLES(ERASE_CYCLES), .TOP_BOOT(TOP_BOOT)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCmd(wrCmd),
  .wrSec(wrAddr[ADDR_W-1:WORD_W]), .rdEn(rdEn), .rdValid(rdValid),
  .wpEn(wpEn), .secProtect(secProtect), .ready(ready),
  .opDone(ctl.doProg || ctl.doErase)
);

// File: tb/dual_bank_flash_ctl_tb.sv
`timescale 1ns/1ps
module dual_bank_flash_ctl_tb;
  localparam int P = 6;
  localparam int E = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrCmd = 2'd0;
  logic [4:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic rdEn = 1'b0;
  logic [4:0] rdAddr = '0;
  logic [15:0] rdData;
  logic rdValid;
  logic wpEn = 1'b0;
  logic [7:0] secProtect = '0;
  logic ready;

  int checks = 0;
  int fails = 0;
  int busyCnt = 0;
  logic busyClr = 1'b0;

  always #2.5 clk = ~clk;

  dual_bank_flash_ctl #(.PROG_CYCLES(P), .ERASE_CYCLES(E)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCmd(wrCmd), .wrAddr(wrAddr),
    .wrData(wrData), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .rdValid(rdValid), .wpEn(wpEn), .secProtect(secProtect), .ready(ready)
  );

  always @(posedge clk) begin
    if (busyClr) busyCnt <= 0;
    else if (!ready) busyCnt <= busyCnt + 1;
  end

  // kind: 0 program, 1 erase, 2 read; addr; data; expected
  localparam logic [38:0] VEC [0:11] = '{
    {2'd0, 5'd9,  16'hA5F0, 16'h0000},
    {2'd2, 5'd9,  16'h0000, 16'hA5F0},
    {2'd0, 5'd9,  16'h0FFF, 16'h0000},
    {2'd2, 5'd9,  16'h0000, 16'h05F0},
    {2'd0, 5'd10, 16'h1234, 16'h0000},
    {2'd2, 5'd10, 16'h0000, 16'h1234},
    {2'd2, 5'd11, 16'h0000, 16'hFFFF},
    {2'd1, 5'd8,  16'h0000, 16'h0000},
    {2'd2, 5'd9,  16'h0000, 16'hFFFF},
    {2'd2, 5'd10, 16'h0000, 16'hFFFF},
    {2'd0, 5'd20, 16'h0000, 16'h0000},
    {2'd2, 5'd20, 16'h0000, 16'h0000}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] c, input int a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrCmd = c; wrAddr = 5'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input int a, output logic [15:0] v);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = 5'(a);
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic waitDone(output int n);
    n = 0;
    while (!ready) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic clearBusy();
    @(negedge clk); busyClr = 1'b1;
    @(negedge clk); busyClr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [15:0] v, s1, s2;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R6 reset state
    check(ready == 1'b1, "R6 ready after reset", 32'(ready), 1);
    doRead(0, v);
    check(v == 16'hFFFF, "R6 erased after reset", 32'(v), 32'hFFFF);
    check(rdValid == 1'b1, "R2 rdValid one cycle after rdEn", 32'(rdValid), 1);
    @(negedge clk);
    check(rdValid == 1'b0, "R2 rdValid drops", 32'(rdValid), 0);

    // vector table: R10 AND-program and erase, R4 durations, R5
    for (int i = 0; i < 12; i++) begin
      logic [1:0] k;
      k = VEC[i][38:37];
      if (k == 2'd2) begin
        doRead(int'(VEC[i][36:32]), v);
        check(v == VEC[i][15:0], "R10 array value", 32'(v), 32'(VEC[i][15:0]));
      end else begin
        doWrite(k, int'(VEC[i][36:32]), VEC[i][31:16]);
        waitDone(n);
        check(n == (k == 2'd0 ? P : E), "R4 busy duration", 32'(n), 32'(k == 2'd0 ? P : E));
      end
    end

    doWrite(2'd0, 3, 16'h5A5A); waitDone(n);
    doWrite(2'd0, 17, 16'h0000); waitDone(n);

    // R3 poll bit during program, R12 ignored erase
    clearBusy();
    doWrite(2'd0, 12, 16'h0080);
    doRead(12, v);
    check(v[7] == 1'b0 && (v & 16'hFF3B) == 16'h0, "R3 program poll word", 32'(v), 32'h0);
    doRead(1, v);
    check(v == 16'hFFFF, "R1 idle bank array read", 32'(v), 32'hFFFF);
    doWrite(2'd1, 12, 16'h0000);
    waitDone(n);
    check(busyCnt == P, "R12 erase while busy ignored", 32'(busyCnt), P);
    doRead(12, v);
    check(v == 16'h0080, "R12 R5 data after program", 32'(v), 32'h0080);

    // erase sector 4 with suspend / program / resume
    clearBusy();
    doWrite(2'd1, 16, 16'h0000);
    doRead(3, v);
    check(v == 16'h5A5A, "R2 other bank during erase", 32'(v), 32'h5A5A);
    doRead(17, s1);
    check(s1[7] == 1'b0 && (s1 & 16'hFF3B) == 16'h0, "R3 erase poll word", 32'(s1), 32'h0);
    doRead(17, s2);
    check(s2[6] != s1[6] && s2[2] != s1[2], "R11 toggles in erasing sector", 32'({s1, s2}), 0);
    doRead(24, s1);
    doRead(24, s2);
    check(s2[6] != s1[6] && s2[2] == s1[2], "R11 bit2 steady outside sector", 32'({s1, s2}), 0);
    doWrite(2'd2, 16, 16'h0000);
    check(ready == 1'b1, "R7 ready in suspend", 32'(ready), 1);
    doRead(17, s1);
    doRead(17, s2);
    check(s2[2] != s1[2] && s2[6] == s1[6] && s2[7], "R11 R7 suspended sector status", 32'({s1, s2}), 0);
    doRead(28, v);
    check(v == 16'hFFFF, "R7 array read in suspend", 32'(v), 32'hFFFF);
    doWrite(2'd0, 29, 16'h0F0F);
    check(ready == 1'b0, "R7 program in suspend accepted", 32'(ready), 0);
    doRead(17, v);
    check(v[7] == 1'b1, "R3 poll complement during suspend program", 32'(v), 1);
    waitDone(n);
    doRead(29, v);
    check(v == 16'h0F0F, "R7 suspend program data", 32'(v), 32'h0F0F);
    doWrite(2'd0, 16, 16'h0000);
    check(ready == 1'b1, "R7 program to suspended sector rejected", 32'(ready), 1);
    doWrite(2'd3, 16, 16'h0000);
    check(ready == 1'b0, "R7 resume busy", 32'(ready), 0);
    waitDone(n);
    check(busyCnt == E + P, "R4 erase time summed over suspend", 32'(busyCnt), E + P);
    doRead(17, v);
    check(v == 16'hFFFF, "R10 erase sets ones", 32'(v), 32'hFFFF);
    doRead(16, v);
    check(v == 16'hFFFF, "R7 rejected program left word", 32'(v), 32'hFFFF);

    // R8 boot lock
    wpEn = 1'b1;
    doWrite(2'd0, 2, 16'h0000);
    check(ready == 1'b1, "R8 boot program rejected", 32'(ready), 1);
    doRead(2, v);
    check(v == 16'hFFFF, "R8 boot word unchanged", 32'(v), 32'hFFFF);
    doWrite(2'd1, 3, 16'h0000);
    check(ready == 1'b1, "R8 boot erase rejected", 32'(ready), 1);
    doRead(3, v);
    check(v == 16'h5A5A, "R8 boot sector kept", 32'(v), 32'h5A5A);
    doWrite(2'd0, 9, 16'h7777);
    check(ready == 1'b0, "R8 non-boot accepted", 32'(ready), 0);
    waitDone(n);
    wpEn = 1'b0;

    // R9 sector protect
    secProtect = 8'b0010_0000;
    doWrite(2'd0, 21, 16'h0000);
    check(ready == 1'b1, "R9 protected program rejected", 32'(ready), 1);
    doRead(21, v);
    check(v == 16'hFFFF, "R9 protected word unchanged", 32'(v), 32'hFFFF);
    secProtect = '0;

    // R6 reset aborts
    doWrite(2'd0, 22, 16'h0000);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check(ready == 1'b1, "R6 reset aborts operation", 32'(ready), 1);
    rstN = 1'b1;
    doRead(22, v);
    check(v == 16'hFFFF, "R6 aborted word", 32'(v), 32'hFFFF);
    doRead(3, v);
    check(v == 16'hFFFF, "R6 array cleared", 32'(v), 32'hFFFF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule